// File: doc/BRIEF.md
# Clock Configuration Register Slave on I2C

This block is a serial-bus target that holds six 8-bit configuration bytes for a clock generator. The bytes appear on a parallel output bus that steers frequency selection and clock gating elsewhere on the chip. A host reaches them over the two-wire I2C bus in standard mode. SCL and SDA arrive as plain inputs. SDA leaves the block as a drive-low enable for an open-drain pad.

The host writes the bytes with a block-write transfer. The transfer carries an address byte, then a command byte and a count byte that the block takes and throws away, then data bytes that land in registers 0 upward. The host reads the bytes back with a block-read transfer. In a read, the block sends a byte count first and then every register in order.

Both bus lines pass through two-flop synchronisers and are sampled by a system clock at least sixteen times faster than SCL. The controller is a state machine with seven states:

- `ST_IDLE` ignores the bus until a START.
- `ST_ADDR` shifts in the address byte.
- `ST_ADDR_ACK` and `ST_WR_ACK` hold SDA low for the acknowledge bit.
- `ST_WR_BYTE` shifts in a write byte.
- `ST_RD_BYTE` shifts out a read byte.
- `ST_RD_ACK` samples the host's acknowledge.

The transitions are:

- START moves any state to `ST_ADDR`, and STOP moves any state to `ST_IDLE`.
- After eight address bits, a matching address goes to `ST_ADDR_ACK`; any other address goes back to `ST_IDLE`.
- From `ST_ADDR_ACK`, a write goes to `ST_WR_BYTE` and a read goes to `ST_RD_BYTE`.
- Write bytes move between `ST_WR_BYTE` and `ST_WR_ACK`.
- Read bytes move between `ST_RD_BYTE` and `ST_RD_ACK`.
- From `ST_RD_ACK`, a host ACK returns to `ST_RD_BYTE` and a host NACK goes to `ST_IDLE`.

Top module: `clkcfg_i2c_slave`

## Requirements
- R1: After reset the register bytes are 0x81, 0x3C, 0x00, 0xFF, 0xFF, 0x5A for registers 0 to 5, and register k appears on `cfg_o[8k+7:8k]`.
- R2: An address byte of 0xD2 (device 0x69, direction bit 0) is acknowledged by pulling SDA low during the ninth clock, and it opens a write.
- R3: An address byte of 0xD3 (direction bit 1) is acknowledged and opens a read.
- R4: Any other address byte is not acknowledged. SDA is then left released, and no register changes, until the next START.
- R5: In a write, the first two bytes after the address (command and count) are acknowledged and change no register.
- R6: Write data bytes are received MSB first and stored in ascending order from register 0 to register 5, each acknowledged. Bytes past register 5 are acknowledged and dropped.
- R7: A STOP after any complete byte ends the write. Registers already written keep their new values and the others are unchanged.
- R8: A read returns the count byte 6 first, then registers 0 to 5, MSB first. Any further byte the host asks for reads as 0xFF.
- R9: A host NACK ends a read. The block then leaves SDA released until the next START.
- R10: The block changes its SDA drive only while SCL is low.
- R11: A START or STOP seen before a byte is acknowledged drops that byte unstored. A START always begins a fresh address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | When high, the pad pulls SDA low |
| cfg_o | output | 48 | Six configuration bytes; register k in bits [8k+7:8k] |

## Verification
The two events that can meet are a byte completing and a bus condition arriving. When the eighth SCL rise of a write byte has been taken, the next SCL fall would store the byte and start its acknowledge. A STOP that arrives after that rise but before the fall competes with the store. The bench provokes this by raising SDA while SCL is still high in the eighth bit. It then checks at the parallel output that the byte was not stored. A START inside a half-sent byte is provoked in the same way, and the fresh address phase that follows is checked by a read.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_ADDR     = 3'd1,
        ST_ADDR_ACK = 3'd2,
        ST_WR_BYTE  = 3'd3,
        ST_WR_ACK   = 3'd4,
        ST_RD_BYTE  = 3'd5,
        ST_RD_ACK   = 3'd6
    } state_t;

    localparam int BYTE_BITS = 8;
    localparam int BITCNT_W  = $clog2(BYTE_BITS + 1);

endpackage

// File: rtl/clkcfg_line_sync.sv
module clkcfg_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_d;
    logic              sda_d;

    // synchroniser chains, idle-high
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_d    <= scl_pipe[STAGES-1];
            sda_d    <= sda_pipe[STAGES-1];
        end
    end

    assign scl_s     = scl_pipe[STAGES-1];
    assign sda_s     = sda_pipe[STAGES-1];
    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    // SDA edge while SCL held high over both samples
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/clkcfg_regbank.sv
module clkcfg_regbank #(
    parameter int                        NUM_REGS  = 6,
    parameter int                        IDX_W     = 4,
    parameter logic [NUM_REGS*8-1:0]     RESET_VAL = '0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_idx,
    input  logic [7:0]            wr_data,
    input  logic [IDX_W-1:0]      rd_idx,
    output logic [7:0]            rd_data,
    output logic [NUM_REGS*8-1:0] cfg_o
);
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        logic [7:0] r_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                r_q <= RESET_VAL[g*8 +: 8];
            else if (wr_en && wr_idx == IDX_W'(g))
                r_q <= wr_data;
        end
        assign cfg_o[g*8 +: 8] = r_q;
    end

    // out-of-range reads return the released-bus value
    always_comb begin
        rd_data = 8'hFF;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_idx == IDX_W'(i))
                rd_data = cfg_o[i*8 +: 8];
        end
    end

endmodule

// File: rtl/clkcfg_i2c_slave.sv
module clkcfg_i2c_slave
    import clkcfg_pkg::*;
#(
    parameter int                    NUM_REGS  = 6,
    parameter logic [6:0]            DEV_ADDR  = 7'h69,
    parameter int                    SYNC_STG  = 2,
    parameter logic [NUM_REGS*8-1:0] CFG_RESET = 48'h5A_FF_FF_00_3C_81
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe,
    output logic [NUM_REGS*8-1:0] cfg_o
);
    localparam int IDX_W   = $clog2(NUM_REGS + 3);
    localparam int IDX_MAX = NUM_REGS + 2;
    localparam int HDR_N   = 2;

    state_t state_q, state_d;

    logic scl_sync, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [BITCNT_W-1:0] bit_cnt_q;
    logic [7:0]          shreg_q;
    logic [7:0]          txreg_q;
    logic [IDX_W-1:0]    byte_idx_q, idx_next;
    logic                rd_mode_q, host_ack_q, sda_oe_q;
    logic                byte_end, addr_hit, bus_evt;
    logic                wr_en;
    logic [IDX_W-1:0]    wr_idx, rd_idx;
    logic [7:0]          rd_data, tx_byte;

    clkcfg_line_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_sync),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    clkcfg_regbank #(
        .NUM_REGS  (NUM_REGS),
        .IDX_W     (IDX_W),
        .RESET_VAL (CFG_RESET)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (shreg_q),
        .rd_idx  (rd_idx),
        .rd_data (rd_data),
        .cfg_o   (cfg_o)
    );

    assign bus_evt  = start_det | stop_det;
    assign byte_end = scl_fall && (bit_cnt_q == BITCNT_W'(BYTE_BITS));
    assign addr_hit = (shreg_q[7:1] == DEV_ADDR);
    assign idx_next = (byte_idx_q == IDX_W'(IDX_MAX)) ? byte_idx_q : byte_idx_q + 1'b1;
    assign rd_idx   = byte_idx_q - IDX_W'(1);
    assign tx_byte  = (byte_idx_q == '0) ? 8'(NUM_REGS) : rd_data;
    assign wr_idx   = byte_idx_q - IDX_W'(HDR_N);
    assign wr_en    = (state_q == ST_WR_BYTE) && byte_end && !bus_evt
                   && (byte_idx_q >= IDX_W'(HDR_N))
                   && (byte_idx_q <  IDX_W'(NUM_REGS + HDR_N));
    assign sda_oe   = sda_oe_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (start_det) begin
            state_d = ST_ADDR;
        end else if (stop_det) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:     state_d = ST_IDLE;
                ST_ADDR:     if (byte_end) state_d = addr_hit ? ST_ADDR_ACK : ST_IDLE;
                ST_ADDR_ACK: if (scl_fall) state_d = rd_mode_q ? ST_RD_BYTE : ST_WR_BYTE;
                ST_WR_BYTE:  if (byte_end) state_d = ST_WR_ACK;
                ST_WR_ACK:   if (scl_fall) state_d = ST_WR_BYTE;
                ST_RD_BYTE:  if (byte_end) state_d = ST_RD_ACK;
                ST_RD_ACK:   if (scl_fall) state_d = host_ack_q ? ST_RD_BYTE : ST_IDLE;
                default:     state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath and SDA drive
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt_q  <= '0;
            shreg_q    <= '0;
            txreg_q    <= '0;
            byte_idx_q <= '0;
            rd_mode_q  <= 1'b0;
            host_ack_q <= 1'b0;
            sda_oe_q   <= 1'b0;
        end else if (bus_evt) begin
            bit_cnt_q <= '0;
            sda_oe_q  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    bit_cnt_q <= '0;
                end
                ST_ADDR, ST_WR_BYTE: begin
                    if (scl_rise) begin
                        shreg_q   <= {shreg_q[6:0], sda_s};
                        bit_cnt_q <= bit_cnt_q + 1'b1;
                    end else if (byte_end) begin
                        bit_cnt_q <= '0;
                        if (state_q == ST_ADDR) begin
                            if (addr_hit) begin
                                sda_oe_q   <= 1'b1;
                                rd_mode_q  <= shreg_q[0];
                                byte_idx_q <= '0;
                            end
                        end else begin
                            sda_oe_q   <= 1'b1;
                            byte_idx_q <= idx_next;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        if (rd_mode_q) begin
                            txreg_q    <= {tx_byte[6:0], 1'b1};
                            sda_oe_q   <= ~tx_byte[7];
                            byte_idx_q <= idx_next;
                        end else begin
                            sda_oe_q <= 1'b0;
                        end
                    end
                end
                ST_WR_ACK: begin
                    if (scl_fall) sda_oe_q <= 1'b0;
                end
                ST_RD_BYTE: begin
                    if (scl_rise) begin
                        bit_cnt_q <= bit_cnt_q + 1'b1;
                    end else if (byte_end) begin
                        bit_cnt_q <= '0;
                        sda_oe_q  <= 1'b0;
                    end else if (scl_fall) begin
                        sda_oe_q <= ~txreg_q[7];
                        txreg_q  <= {txreg_q[6:0], 1'b1};
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) begin
                        host_ack_q <= ~sda_s;
                    end else if (scl_fall) begin
                        if (host_ack_q) begin
                            txreg_q    <= {tx_byte[6:0], 1'b1};
                            sda_oe_q   <= ~tx_byte[7];
                            byte_idx_q <= idx_next;
                        end else begin
                            sda_oe_q <= 1'b0;
                        end
                    end
                end
                default: sda_oe_q <= 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/clkcfg_i2c_checker.sv
module clkcfg_i2c_checker
    import clkcfg_pkg::*;
#(
    parameter int NUM_REGS = 6,
    parameter int IDX_W    = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  scl_s,
    input logic                  start_det,
    input logic                  stop_det,
    input logic                  sda_oe,
    input logic                  wr_en,
    input logic [IDX_W-1:0]      wr_idx,
    input logic [NUM_REGS*8-1:0] cfg_o,
    input state_t                state
);
    // R10: a change of SDA drive follows an SCL-low sample or a bus condition
    p_sda_change_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> (!$past(scl_s) || $past(start_det) || $past(stop_det)));

    // R9 / R4: idle means SDA released
    p_idle_released_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_oe);

    // R2 / R6: acknowledge phases hold SDA low
    p_ack_drives_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR_ACK || state == ST_WR_ACK) |-> sda_oe);

    // R7: registers move only on a data-byte store
    p_cfg_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cfg_o));

    // R6: stores never address past the last register
    p_wr_index_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (32'(wr_idx) < NUM_REGS));

    // R11: START always opens a fresh address phase
    p_start_enters_addr_r11: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == ST_ADDR));

endmodule

bind clkcfg_i2c_slave clkcfg_i2c_checker #(
    .NUM_REGS (NUM_REGS),
    .IDX_W    (IDX_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (scl_sync),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_oe    (sda_oe),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .cfg_o     (cfg_o),
    .state     (state_q)
);

// File: tb/clkcfg_i2c_slave_tb.sv
module clkcfg_i2c_slave_tb;

    localparam int Q = 10;  // quarter SCL period in system clocks
    localparam logic [47:0] DEF = 48'h5A_FF_FF_00_3C_81;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic [47:0] cfg_o;
    logic sda_line;

    int n_chk = 0;
    int n_fail = 0;
    int scl_high_changes = 0;
    bit done = 0;

    always #5 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    clkcfg_i2c_slave u_dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_i  (scl_m),
        .sda_i  (sda_line),
        .sda_oe (sda_oe),
        .cfg_o  (cfg_o)
    );

    typedef struct {
        string      req;
        logic [7:0] val;
    } item_t;

    item_t      exp_q[$];
    logic [7:0] obs_val;
    event       obs_ev;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: pops expectations as results appear
    initial begin
        forever begin
            @(obs_ev);
            if (exp_q.size() == 0) begin
                check("R8 unexpected item", 64'(obs_val), 64'hFFFF);
            end else begin
                item_t it;
                it = exp_q.pop_front();
                check(it.req, 64'(obs_val), 64'(it.val));
            end
        end
    end

    // R10: SDA drive must not move while SCL is high
    always @(sda_oe) begin
        if (rst_n === 1'b1 && scl_m === 1'b1) scl_high_changes++;
    end

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic observe(input logic [7:0] v);
        obs_val = v;
        -> obs_ev;
        @(negedge clk);
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b0; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b1; wq();
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; wq();
        scl_m = 1'b1; wq(); wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic recv_bit(output logic b);
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        b = sda_line; wq();
        scl_m = 1'b0; wq();
    endtask

    // driver: send a byte, expect an acknowledge value
    task automatic wbyte(input logic [7:0] d, input string req, input logic exp_ack);
        logic a;
        exp_q.push_back('{req, {7'd0, exp_ack}});
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        recv_bit(a);
        observe({7'd0, ~a});
    endtask

    // driver: read a byte, expect its value, answer ACK or NACK
    task automatic rbyte(input logic [7:0] exp, input string req, input logic ack);
        logic [7:0] d;
        logic b;
        exp_q.push_back('{req, exp});
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            d[i] = b;
        end
        send_bit(~ack);
        observe(d);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R1 reset values", 64'(cfg_o), 64'(DEF));
        check("R1 sda released after reset", 64'(sda_oe), 64'd0);

        // full write: header discarded, data ascending
        i2c_start();
        wbyte(8'hD2, "R2 write address ack", 1'b1);
        wbyte(8'h11, "R5 command ack", 1'b1);
        wbyte(8'h22, "R5 count ack", 1'b1);
        for (int i = 0; i < 6; i++) wbyte(8'(8'h10 + i * 8'h11), "R6 data ack", 1'b1);
        i2c_stop();
        check("R5 R6 full write", 64'(cfg_o), 64'h65_54_43_32_21_10);

        // partial write
        i2c_start();
        wbyte(8'hD2, "R2 write address ack", 1'b1);
        wbyte(8'hFE, "R5 command ack", 1'b1);
        wbyte(8'h01, "R5 count ack", 1'b1);
        wbyte(8'hA0, "R7 data ack", 1'b1);
        wbyte(8'hB1, "R7 data ack", 1'b1);
        i2c_stop();
        check("R7 partial write", 64'(cfg_o), 64'h65_54_43_32_B1_A0);

        // foreign address
        i2c_start();
        wbyte(8'hA4, "R4 foreign address nack", 1'b0);
        wbyte(8'h00, "R4 following byte nack", 1'b0);
        wbyte(8'h7F, "R4 following byte nack", 1'b0);
        i2c_stop();
        check("R4 registers untouched", 64'(cfg_o), 64'h65_54_43_32_B1_A0);

        // full read with one byte beyond the end
        i2c_start();
        wbyte(8'hD3, "R3 read address ack", 1'b1);
        rbyte(8'd6, "R8 count byte", 1'b1);
        rbyte(8'hA0, "R8 reg0", 1'b1);
        rbyte(8'hB1, "R8 reg1", 1'b1);
        rbyte(8'h32, "R8 reg2", 1'b1);
        rbyte(8'h43, "R8 reg3", 1'b1);
        rbyte(8'h54, "R8 reg4", 1'b1);
        rbyte(8'h65, "R8 reg5", 1'b1);
        rbyte(8'hFF, "R8 past end", 1'b0);
        i2c_stop();

        // early NACK: bus stays released
        i2c_start();
        wbyte(8'hD3, "R3 read address ack", 1'b1);
        rbyte(8'd6, "R9 count before nack", 1'b0);
        rbyte(8'hFF, "R9 released after nack", 1'b0);
        check("R9 sda released", 64'(sda_oe), 64'd0);
        i2c_stop();

        // overflow write
        i2c_start();
        wbyte(8'hD2, "R2 write address ack", 1'b1);
        wbyte(8'h00, "R5 command ack", 1'b1);
        wbyte(8'h00, "R5 count ack", 1'b1);
        for (int i = 0; i < 8; i++) wbyte(8'(8'hC0 + i), "R6 data ack incl overflow", 1'b1);
        i2c_stop();
        check("R6 overflow dropped", 64'(cfg_o), 64'hC5_C4_C3_C2_C1_C0);

        // START inside a byte, then a fresh read
        i2c_start();
        wbyte(8'hD2, "R2 write address ack", 1'b1);
        wbyte(8'h00, "R5 command ack", 1'b1);
        wbyte(8'h00, "R5 count ack", 1'b1);
        wbyte(8'hE0, "R6 data ack", 1'b1);
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        i2c_start();
        wbyte(8'hD3, "R11 fresh address after start", 1'b1);
        rbyte(8'd6, "R11 count after restart", 1'b1);
        rbyte(8'hE0, "R11 reg0 after restart", 1'b0);
        i2c_stop();
        check("R11 half byte dropped on start", 64'(cfg_o), 64'hC5_C4_C3_C2_C1_E0);

        // STOP after eighth rise, before the acknowledge fall
        i2c_start();
        wbyte(8'hD2, "R2 write address ack", 1'b1);
        wbyte(8'h00, "R5 command ack", 1'b1);
        wbyte(8'h00, "R5 count ack", 1'b1);
        for (int i = 0; i < 7; i++) send_bit(1'b0);
        sda_m = 1'b0; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b1; wq(); wq();
        check("R11 byte dropped on stop", 64'(cfg_o), 64'hC5_C4_C3_C2_C1_E0);
        check("R11 sda released after stop", 64'(sda_oe), 64'd0);

        repeat (4 * Q) @(negedge clk);
        check("R8 scoreboard drained", 64'(exp_q.size()), 64'd0);
        check("R10 no drive change while scl high", 64'(scl_high_changes), 64'd0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule